// File: doc/BRIEF.md
# Hot-Plug Controller Configuration Register Bank

This block is the configuration-space front end of a hot-plug controller function. Software reaches it with byte-enabled reads and writes at dword-aligned offsets. It holds the standard interrupt routing registers, a slot identifier that firmware fills in at boot for later use by drivers, and a miscellaneous control register. Three bits of that register can be written only once after reset.

The write-once bits drive the rest of the controller. One bit switches the device ID reported in configuration space, so the function can be hidden from generic drivers. A second bit raises an inhibit that shuts off the controller's operational registers. A third bit raises a lock that freezes an auto-power-down-disable bit, which is kept in a small guarded cell with its own write port. A plain read/write bit enables power-fault error signalling.

Read data arrives one clock after the read strobe. Write effects show on the outputs after the clock edge that accepts the write.

Top module: `hpc_cfg_bank`

## Requirements
- R1: After reset, the interrupt line reads FFh, the slot identifier reads 0000h and the miscellaneous register reads 0002h. The device ID reads 123Fh, and the inhibit, power-fault enable, lock and guarded bit outputs are all 0.
- R2: The interrupt line is byte 0 of dword offset 3Ch. It is read/write and is written only when byte enable 0 is set.
- R3: The interrupt pin is byte 1 of dword offset 3Ch. It always reads 01h and ignores writes.
- R4: The slot identifier is bits 15:0 of dword offset 40h. Bits 7:4 (first slot device number) and 3:0 (slot count) are writable through byte enable 0. Bits 15:8 always read 0.
- R5: Miscellaneous bit 13 (dword 40h, data bit 29) is a plain read/write power-fault enable, driven on the power-fault enable output.
- R6: Miscellaneous bit 15 (data bit 31) is write-once. While it is 1, the device ID (bits 31:16 of dword offset 00h and the device ID output) is 123Eh. While it is 0, the device ID is 123Fh.
- R7: Miscellaneous bit 14 (data bit 30) is write-once and drives the inhibit output. Once the inhibit output is 1, it never falls before reset.
- R8: The first write to dword 40h with byte enable 3 set marks bits 15, 14 and 12 as written, whatever values it carries. Later writes leave those bits unchanged until reset.
- R9: Miscellaneous bit 12 (data bit 28) is write-once and drives the lock output. While the lock is 0, the guarded write port sets the guarded bit. While the lock is 1, the guarded bit holds its value.
- R10: Miscellaneous bits 11:0 always read 002h and ignore writes. Byte-enable-2 writes change nothing and do not mark the write-once bits.
- R11: Reads from offsets other than 00h, 3Ch and 40h return 0. Writes to those offsets change no register.
- R12: Read data and its valid flag appear the cycle after the read strobe. The valid flag is 0 in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_rd | input | 1 | Read strobe |
| cfg_wr | input | 1 | Write strobe |
| cfg_addr | input | 6 | Dword offset (byte offset bits 7:2) |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, registered |
| cfg_rvalid | output | 1 | Read data valid |
| dev_id_o | output | 16 | Effective device ID |
| hp_inhibit_o | output | 1 | Blocks operational register access |
| pf_enable_o | output | 1 | Power-fault signalling enable |
| apd_lock_o | output | 1 | Freezes the guarded bit |
| apd_wr | input | 1 | Guarded bit write strobe |
| apd_wdata | input | 1 | Guarded bit write value |
| apd_disable_o | output | 1 | Guarded auto-power-down-disable bit |

## Verification
Read data is due exactly one cycle after the read strobe. The bench drives the strobe on a falling edge and pushes the expected word into a queue. A monitor then pops the queue on the next falling edge where valid is high, so each result is compared in the one cycle it is due, and a valid with no pending expectation counts as a failure. Write effects on the device ID, inhibit, lock, enable and guarded outputs take one edge, and they are sampled on the falling edge right after the accepting edge. The write-once cases are run in two reset epochs: one where the first write carries zeros and one where it carries ones.

// File: rtl/hpc_cfg_pkg.sv
package hpc_cfg_pkg;
    localparam int CFG_DW = 32;
    localparam int OFF_W  = 6;
    localparam logic [OFF_W-1:0] OFF_IDS  = 6'h00; // byte 00h
    localparam logic [OFF_W-1:0] OFF_INTR = 6'h0F; // byte 3Ch
    localparam logic [OFF_W-1:0] OFF_HP   = 6'h10; // byte 40h
    localparam int NUM_WO = 3;
    localparam logic [7:0]  INT_LINE_RST = 8'hFF;
    localparam logic [7:0]  INT_PIN_VAL  = 8'h01;
    localparam logic [11:0] MISC_FIXED   = 12'h002;

    typedef struct packed {
        logic [7:0]        int_line;
        logic [7:0]        slot_info;
        logic              pf_en;
        logic [CFG_DW-1:0] rdata;
        logic              rvalid;
    } bank_state_t;

    typedef struct packed {
        logic val;
        logic done;
    } wo_state_t;
endpackage

// File: rtl/hpc_wo_bit.sv
module hpc_wo_bit
    import hpc_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lane_wr,
    input  logic wbit,
    output logic val_o
);
    wo_state_t cur_q, cur_d;

    always_comb begin
        cur_d = cur_q;
        if (lane_wr && !cur_q.done) begin
            cur_d.val  = wbit;
            cur_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    assign val_o = cur_q.val;

    // R8
    wo_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.done |=> $stable(cur_q.val));
endmodule

// File: rtl/hpc_apd_guard.sv
module hpc_apd_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic lock,
    input  logic wr,
    input  logic wbit,
    output logic bit_o
);
    logic bit_q, bit_d;

    always_comb begin
        bit_d = bit_q;
        if (wr && !lock) bit_d = wbit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
    end

    assign bit_o = bit_q;

    // R9
    apd_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(bit_q));
endmodule

// File: rtl/hpc_cfg_bank.sv
module hpc_cfg_bank
    import hpc_cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID    = 16'hC0DE,
    parameter logic [15:0] DEVID_SHOWN  = 16'h123F,
    parameter logic [15:0] DEVID_HIDDEN = 16'h123E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_rd,
    input  logic              cfg_wr,
    input  logic [OFF_W-1:0]  cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    output logic              cfg_rvalid,
    output logic [15:0]       dev_id_o,
    output logic              hp_inhibit_o,
    output logic              pf_enable_o,
    output logic              apd_lock_o,
    input  logic              apd_wr,
    input  logic              apd_wdata,
    output logic              apd_disable_o
);
    // write-once cells: 0 -> misc bit 12, 1 -> bit 14, 2 -> bit 15
    localparam int WO_POS [NUM_WO] = '{12, 14, 15};

    bank_state_t st_q, st_d;
    logic [NUM_WO-1:0] wo_val;
    logic              hp_lane3_wr;
    logic [15:0]       misc_rd;

    assign hp_lane3_wr = cfg_wr && (cfg_addr == OFF_HP) && cfg_be[3];

    for (genvar g = 0; g < NUM_WO; g++) begin : g_wo
        hpc_wo_bit u_wo (
            .clk     (clk),
            .rst_n   (rst_n),
            .lane_wr (hp_lane3_wr),
            .wbit    (cfg_wdata[16 + WO_POS[g]]),
            .val_o   (wo_val[g])
        );
    end

    hpc_apd_guard u_apd (
        .clk   (clk),
        .rst_n (rst_n),
        .lock  (wo_val[0]),
        .wr    (apd_wr),
        .wbit  (apd_wdata),
        .bit_o (apd_disable_o)
    );

    assign dev_id_o     = wo_val[2] ? DEVID_HIDDEN : DEVID_SHOWN;
    assign hp_inhibit_o = wo_val[1];
    assign apd_lock_o   = wo_val[0];
    assign pf_enable_o  = st_q.pf_en;
    assign misc_rd      = {wo_val[2], wo_val[1], st_q.pf_en, wo_val[0], MISC_FIXED};

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = cfg_rd;
        if (cfg_wr) begin
            if (cfg_addr == OFF_INTR && cfg_be[0]) st_d.int_line  = cfg_wdata[7:0];
            if (cfg_addr == OFF_HP   && cfg_be[0]) st_d.slot_info = cfg_wdata[7:0];
            if (cfg_addr == OFF_HP   && cfg_be[3]) st_d.pf_en     = cfg_wdata[29];
        end
        if (cfg_rd) begin
            case (cfg_addr)
                OFF_IDS:  st_d.rdata = {dev_id_o, VENDOR_ID};
                OFF_INTR: st_d.rdata = {16'h0000, INT_PIN_VAL, st_q.int_line};
                OFF_HP:   st_d.rdata = {misc_rd, 8'h00, st_q.slot_info};
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.int_line <= INT_LINE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_rdata  = st_q.rdata;
    assign cfg_rvalid = st_q.rvalid;

    // R7
    inhibit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(hp_inhibit_o));
    // R12
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd |=> cfg_rvalid);
    // R3
    int_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_addr == OFF_INTR) |=> (cfg_rdata[15:8] == 8'h01));
    // R4
    slot_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_addr == OFF_HP) |=> (cfg_rdata[15:8] == 8'h00));
    // R10
    misc_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_addr == OFF_HP) |=> (cfg_rdata[27:16] == 12'h002));
endmodule

// File: tb/hpc_cfg_bank_bench.sv
module hpc_cfg_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_rd = 1'b0, cfg_wr = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_rvalid;
    logic [15:0] dev_id_o;
    logic        hp_inhibit_o, pf_enable_o, apd_lock_o, apd_disable_o;
    logic        apd_wr = 1'b0, apd_wdata = 1'b0;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    hpc_cfg_bank u_hpc_cfg_bank (
        .clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid), .dev_id_o(dev_id_o),
        .hp_inhibit_o(hp_inhibit_o), .pf_enable_o(pf_enable_o),
        .apd_lock_o(apd_lock_o), .apd_wr(apd_wr), .apd_wdata(apd_wdata),
        .apd_disable_o(apd_disable_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // monitor: read data is due one edge after the strobe
    always @(negedge clk) begin
        if (rst_n && cfg_rvalid) begin
            if (sb_q.size() == 0) begin
                check("R12 unexpected rvalid", 32'd1, 32'd0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(it.tag, cfg_rdata, it.exp);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_read(logic [7:0] byte_off, logic [31:0] exp, string tag);
        @(negedge clk);
        cfg_rd   = 1'b1;
        cfg_addr = byte_off[7:2];
        sb_q.push_back('{exp, tag});
        @(negedge clk);
        cfg_rd = 1'b0;
    endtask

    task automatic do_write(logic [7:0] byte_off, logic [3:0] be, logic [31:0] d);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_addr  = byte_off[7:2];
        cfg_be    = be;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        cfg_be = '0;
    endtask

    task automatic do_apd(logic v);
        @(negedge clk);
        apd_wr    = 1'b1;
        apd_wdata = v;
        @(negedge clk);
        apd_wr = 1'b0;
    endtask

    task automatic drain();
        repeat (2) @(negedge clk);
        check("R12 pending reads", sb_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R12 watchdog act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 dev_id", dev_id_o, 16'h123F);
        check("R1 outputs", {hp_inhibit_o, pf_enable_o, apd_lock_o, apd_disable_o}, 4'b0);
        do_read(8'h3C, 32'h0000_01FF, "R1 intr reset");
        do_read(8'h40, 32'h0002_0000, "R1 hp reset");
        do_read(8'h00, 32'h123F_C0DE, "R1 ids reset");
        // R12 no read -> no valid
        @(negedge clk);
        check("R12 idle rvalid", cfg_rvalid, 1'b0);

        // R2 / R3
        do_write(8'h3C, 4'b0011, 32'hFFFF_A55A);
        do_read(8'h3C, 32'h0000_015A, "R2 R3 line written pin fixed");
        do_write(8'h3C, 4'b0010, 32'h0000_7733);
        do_read(8'h3C, 32'h0000_015A, "R2 lane0 off keeps line");

        // R4
        do_write(8'h40, 4'b0011, 32'h0000_FF37);
        do_read(8'h40, 32'h0002_0037, "R4 slot fields");

        // R8 first write carries zeros for write-once bits, R5 sets enable
        do_write(8'h40, 4'b1000, 32'h2000_0000);
        check("R5 pf enable set", pf_enable_o, 1'b1);
        do_read(8'h40, 32'h2002_0037, "R5 R8 misc after first write");
        do_write(8'h40, 4'b1000, 32'hD000_0000);
        check("R5 pf enable cleared", pf_enable_o, 1'b0);
        check("R8 inhibit frozen at 0", hp_inhibit_o, 1'b0);
        check("R8 dev_id frozen", dev_id_o, 16'h123F);
        check("R8 lock frozen at 0", apd_lock_o, 1'b0);
        do_read(8'h40, 32'h0002_0037, "R8 misc after second write");

        // R9 unlocked: guarded bit follows port
        do_apd(1'b1);
        check("R9 guarded set unlocked", apd_disable_o, 1'b1);
        do_apd(1'b0);
        check("R9 guarded clear unlocked", apd_disable_o, 1'b0);
        drain();

        // second epoch
        do_reset();
        check("R1 dev_id after reset", dev_id_o, 16'h123F);
        do_read(8'h3C, 32'h0000_01FF, "R1 intr after reset");
        // R10 lane 2 write ignored and does not mark write-once bits
        do_write(8'h40, 4'b0100, 32'hFFFF_FFFF);
        do_read(8'h40, 32'h0002_0000, "R10 lane2 ignored");
        do_apd(1'b1);
        check("R9 guarded set before lock", apd_disable_o, 1'b1);
        do_write(8'h40, 4'b1000, 32'hF000_0000);
        check("R6 dev_id hidden", dev_id_o, 16'h123E);
        check("R7 inhibit set", hp_inhibit_o, 1'b1);
        check("R9 lock set", apd_lock_o, 1'b1);
        do_read(8'h00, 32'h123E_C0DE, "R6 ids hidden");
        do_read(8'h40, 32'hF002_0000, "R10 R8 misc ones");
        do_apd(1'b0);
        check("R9 guarded held while locked", apd_disable_o, 1'b1);
        do_write(8'h40, 4'b1000, 32'h0000_0000);
        check("R7 inhibit stays", hp_inhibit_o, 1'b1);
        do_read(8'h40, 32'hD002_0000, "R8 R5 only enable cleared");

        // R11 unmapped
        do_write(8'h20, 4'b1111, 32'hFFFF_FFFF);
        do_write(8'h44, 4'b1111, 32'hFFFF_FFFF);
        do_read(8'h20, 32'h0000_0000, "R11 unmapped read");
        do_read(8'h44, 32'h0000_0000, "R11 unmapped read 44");
        do_read(8'h3C, 32'h0000_01FF, "R11 intr untouched");
        do_read(8'h40, 32'hD002_0000, "R11 hp untouched");
        drain();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule